// File: doc/BRIEF.md
# Vector Configuration and Control-State Unit

This block keeps the user-visible control state of a vector unit whose registers are 128 bits wide. It holds the start index, the fixed-point saturation flag and rounding mode, the active vector length and the active element type. It serves CSR reads and writes on a simple request port. It also serves configuration requests that carry a requested application vector length (AVL) and a proposed type word. From the element width and the register-group multiplier it derives the largest legal length. It then grants the smaller of that limit and the AVL, and marks configurations it cannot honour as illegal.

The issue stage presents each vector instruction with its class (arithmetic, load or store), and the block reports at once whether that instruction may run under the current start index and type. When an instruction completes, the start index returns to zero. The datapath reports fixed-point saturation on a sticky input. The block also owns the two-bit vector-state field of the machine status word, which goes to Dirty whenever vector state changes.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vl is 0, vtype holds only the illegal flag (bit XLEN-1), vstart, vxsat and vxrm are 0, and the vector-state field reads 01 (Initial).
- R2: CSR addresses: vstart 0x008, vxsat 0x009, vxrm 0x00A, vcsr 0x00F, vl 0xC20, vtype 0xC21, vlenb 0xC22. csr_hit_o is 1 exactly for these addresses. vlenb reads VLEN/8 (16), and any other address reads 0.
- R3: The type word holds LMUL code in bits 2:0 (0..3 for 1,2,4,8) and SEW code in bits 5:3 (0..3 for 8,16,32,64). Bit 6 is tail-agnostic and bit 7 is mask-agnostic. A configuration grants vl = min(AVL, (VLEN/SEW)*LMUL) on cfg_vl_o in the same cycle, and it loads vl and vtype at the next edge.
- R4: A SEW code of 4 or more, an LMUL code of 4 or more, or any set bit in positions XLEN-2..8 makes the configuration illegal. In that case vtype becomes the illegal flag alone and vl becomes 0.
- R5: Writes to vl, vtype and vlenb are ignored.
- R6: A vstart write keeps the low log2(VLEN) bits. A retire clears vstart at the next edge and takes priority over a vstart write in the same cycle.
- R7: Instruction classes are arithmetic 00, load 01 and store 10. issue_illegal_o is 1 when vtype is illegal. It is also 1 when vstart is nonzero and the class is not store.
- R8: vxsat implements only bit 0, and its upper bits read 0. sat_set_i sets the flag at the next edge. When a write and sat_set_i fall in the same cycle, the written value is ORed with sat_set_i.
- R9: vxrm is two bits and drives vxrm_o. vcsr bit 0 is vxsat and bits 2:1 are vxrm, with the upper bits reading 0. Writes through vcsr update both fields.
- R10: Any write to vstart, vxsat, vxrm or vcsr, any configuration, and any retire set the vector-state field to 11 (Dirty). Reads and issue checks leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_valid_i | input | 1 | CSR request present |
| csr_we_i | input | 1 | CSR request is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_hit_o | output | 1 | Address belongs to this block |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_avl_i | input | XLEN | Requested vector length |
| cfg_vtype_i | input | XLEN | Proposed type word |
| cfg_vl_o | output | log2(VLEN)+1 | Granted length for the present request |
| sat_set_i | input | 1 | Datapath saturation report |
| issue_valid_i | input | 1 | Instruction presented for legality check |
| issue_kind_i | input | 2 | Instruction class |
| issue_illegal_o | output | 1 | Instruction must raise illegal-instruction |
| retire_i | input | 1 | A vector instruction completes |
| vl_o | output | log2(VLEN)+1 | Current vl |
| vtype_o | output | XLEN | Current vtype |
| vstart_o | output | log2(VLEN) | Current vstart |
| vxrm_o | output | 2 | Current rounding mode |
| vs_o | output | 2 | Vector-state field of the status word |

## Verification
The bench builds the block with its defaults, XLEN = 64 and VLEN = 128. With these values the granted length ranges from 2 (SEW 64, LMUL 1) to 128 (SEW 8, LMUL 8), so both the clamp to VLMAX and the pass-through of small AVLs can be observed. A 64-bit AVL of 1000 exercises the compare over the full width. The reserved-bit illegality check also covers a wide span of bits.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam logic [11:0] ADDR_VSTART = 12'h008;
    localparam logic [11:0] ADDR_VXSAT  = 12'h009;
    localparam logic [11:0] ADDR_VXRM   = 12'h00A;
    localparam logic [11:0] ADDR_VCSR   = 12'h00F;
    localparam logic [11:0] ADDR_VL     = 12'hC20;
    localparam logic [11:0] ADDR_VTYPE  = 12'hC21;
    localparam logic [11:0] ADDR_VLENB  = 12'hC22;

    typedef enum logic [1:0] {
        KIND_ARITH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10
    } issue_kind_e;

    typedef enum logic [1:0] {
        VS_OFF     = 2'b00,
        VS_INITIAL = 2'b01,
        VS_CLEAN   = 2'b10,
        VS_DIRTY   = 2'b11
    } vs_state_e;

    typedef struct packed {
        logic       vma;
        logic       vta;
        logic [2:0] sew;
        logic [2:0] lmul;
    } vtype_low_t;

    // Largest element count for a width code and a group-size code.
    function automatic int unsigned group_elems(int unsigned vlen_bits,
                                                logic [1:0] sew_code,
                                                logic [1:0] lmul_code);
        return ((vlen_bits / 8) >> sew_code) << lmul_code;
    endfunction

endpackage

// File: rtl/vcfg_setvl.sv
module vcfg_setvl
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic [XLEN-1:0]        avl_i,
    input  logic [XLEN-1:0]        vtype_i,
    output logic [$clog2(VLEN):0]  vl_o,
    output logic [XLEN-1:0]        vtype_o
);
    localparam int VL_W = $clog2(VLEN) + 1;

    vtype_low_t           low;
    logic                 bad_code;
    logic                 bad_rsvd;
    logic [VL_W-1:0]      limit;

    assign low      = vtype_i[7:0];
    assign bad_code = low.sew[2] | low.lmul[2];
    assign bad_rsvd = |vtype_i[XLEN-2:8];
    assign limit    = VL_W'(group_elems(VLEN, low.sew[1:0], low.lmul[1:0]));

    always_comb begin
        if (bad_code || bad_rsvd) begin
            vl_o    = '0;
            vtype_o = {1'b1, {(XLEN-1){1'b0}}};
        end else begin
            vl_o    = (avl_i < XLEN'(limit)) ? avl_i[VL_W-1:0] : limit;
            vtype_o = {1'b0, {(XLEN-9){1'b0}}, low};
        end
    end

    logic unused_ill_in;
    assign unused_ill_in = vtype_i[XLEN-1];

endmodule

// File: rtl/vcfg_fixpt.sv
module vcfg_fixpt (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_sat_i,
    input  logic       wr_rm_i,
    input  logic       wr_both_i,
    input  logic [2:0] wdata_i,
    input  logic       sat_set_i,
    output logic       sat_o,
    output logic [1:0] rm_o
);
    logic       sat_q;
    logic [1:0] rm_q;
    logic       sat_base;
    logic [1:0] rm_next;

    always_comb begin
        sat_base = sat_q;
        if (wr_sat_i)       sat_base = wdata_i[0];
        else if (wr_both_i) sat_base = wdata_i[0];
        rm_next = rm_q;
        if (wr_rm_i)        rm_next = wdata_i[1:0];
        else if (wr_both_i) rm_next = wdata_i[2:1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sat_q <= 1'b0;
            rm_q  <= 2'b00;
        end else begin
            sat_q <= sat_base | sat_set_i;
            rm_q  <= rm_next;
        end
    end

    assign sat_o = sat_q;
    assign rm_o  = rm_q;

endmodule

// File: rtl/vcfg_issue_chk.sv
module vcfg_issue_chk
    import vcfg_pkg::*;
#(
    parameter int VSTART_W = 7
) (
    input  logic                issue_valid_i,
    input  logic [1:0]          issue_kind_i,
    input  logic [VSTART_W-1:0] vstart_i,
    input  logic                vill_i,
    output logic                illegal_o
);
    logic resumable;
    logic mid_run;

    assign resumable = (issue_kind_i == KIND_STORE);
    assign mid_run   = (vstart_i != '0);
    assign illegal_o = issue_valid_i && (vill_i || (mid_run && !resumable));

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     csr_valid_i,
    input  logic                     csr_we_i,
    input  logic [11:0]              csr_addr_i,
    input  logic [XLEN-1:0]          csr_wdata_i,
    output logic [XLEN-1:0]          csr_rdata_o,
    output logic                     csr_hit_o,
    input  logic                     cfg_valid_i,
    input  logic [XLEN-1:0]          cfg_avl_i,
    input  logic [XLEN-1:0]          cfg_vtype_i,
    output logic [$clog2(VLEN):0]    cfg_vl_o,
    input  logic                     sat_set_i,
    input  logic                     issue_valid_i,
    input  logic [1:0]               issue_kind_i,
    output logic                     issue_illegal_o,
    input  logic                     retire_i,
    output logic [$clog2(VLEN):0]    vl_o,
    output logic [XLEN-1:0]          vtype_o,
    output logic [$clog2(VLEN)-1:0]  vstart_o,
    output logic [1:0]               vxrm_o,
    output logic [1:0]               vs_o
);
    localparam int VL_W     = $clog2(VLEN) + 1;
    localparam int VSTART_W = $clog2(VLEN);
    localparam int VLENB    = VLEN / 8;

    logic                wr_en;
    logic                wr_vstart, wr_vxsat, wr_vxrm, wr_vcsr;
    logic                state_touch;
    logic [VL_W-1:0]     vl_q;
    logic [XLEN-1:0]     vtype_q;
    logic [VSTART_W-1:0] vstart_q;
    vs_state_e           vs_q;
    logic [XLEN-1:0]     new_vtype;
    logic                sat;
    logic [1:0]          rm;

    assign wr_en     = csr_valid_i && csr_we_i;
    assign wr_vstart = wr_en && (csr_addr_i == ADDR_VSTART);
    assign wr_vxsat  = wr_en && (csr_addr_i == ADDR_VXSAT);
    assign wr_vxrm   = wr_en && (csr_addr_i == ADDR_VXRM);
    assign wr_vcsr   = wr_en && (csr_addr_i == ADDR_VCSR);
    assign state_touch = wr_vstart || wr_vxsat || wr_vxrm || wr_vcsr
                       || cfg_valid_i || retire_i;

    vcfg_setvl #(.XLEN(XLEN), .VLEN(VLEN)) u_setvl (
        .avl_i   (cfg_avl_i),
        .vtype_i (cfg_vtype_i),
        .vl_o    (cfg_vl_o),
        .vtype_o (new_vtype)
    );

    vcfg_fixpt u_fixpt (
        .clk       (clk),
        .rst       (rst),
        .wr_sat_i  (wr_vxsat),
        .wr_rm_i   (wr_vxrm),
        .wr_both_i (wr_vcsr),
        .wdata_i   (csr_wdata_i[2:0]),
        .sat_set_i (sat_set_i),
        .sat_o     (sat),
        .rm_o      (rm)
    );

    vcfg_issue_chk #(.VSTART_W(VSTART_W)) u_issue (
        .issue_valid_i (issue_valid_i),
        .issue_kind_i  (issue_kind_i),
        .vstart_i      (vstart_q),
        .vill_i        (vtype_q[XLEN-1]),
        .illegal_o     (issue_illegal_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q     <= '0;
            vtype_q  <= {1'b1, {(XLEN-1){1'b0}}};
            vstart_q <= '0;
            vs_q     <= VS_INITIAL;
        end else begin
            if (cfg_valid_i) begin
                vl_q    <= cfg_vl_o;
                vtype_q <= new_vtype;
            end
            if (retire_i)
                vstart_q <= '0;
            else if (wr_vstart)
                vstart_q <= csr_wdata_i[VSTART_W-1:0];
            if (state_touch)
                vs_q <= VS_DIRTY;
        end
    end

    always_comb begin
        csr_hit_o   = 1'b1;
        csr_rdata_o = '0;
        unique case (csr_addr_i)
            ADDR_VSTART: csr_rdata_o = XLEN'(vstart_q);
            ADDR_VXSAT:  csr_rdata_o = XLEN'(sat);
            ADDR_VXRM:   csr_rdata_o = XLEN'(rm);
            ADDR_VCSR:   csr_rdata_o = XLEN'({rm, sat});
            ADDR_VL:     csr_rdata_o = XLEN'(vl_q);
            ADDR_VTYPE:  csr_rdata_o = vtype_q;
            ADDR_VLENB:  csr_rdata_o = XLEN'(VLENB);
            default:     csr_hit_o   = 1'b0;
        endcase
    end

    assign vl_o     = vl_q;
    assign vtype_o  = vtype_q;
    assign vstart_o = vstart_q;
    assign vxrm_o   = rm;
    assign vs_o     = vs_q;

    logic unused_wdata;
    assign unused_wdata = ^csr_wdata_i[XLEN-1:VSTART_W];

endmodule

// File: rtl/vcfg_checker.sv
module vcfg_checker #(
    parameter int XLEN = 64,
    parameter int VLEN = 128
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     csr_valid_i,
    input logic                     csr_we_i,
    input logic [11:0]              csr_addr_i,
    input logic [XLEN-1:0]          csr_rdata_o,
    input logic                     cfg_valid_i,
    input logic                     issue_valid_i,
    input logic [1:0]               issue_kind_i,
    input logic                     issue_illegal_o,
    input logic                     retire_i,
    input logic [$clog2(VLEN):0]    vl_o,
    input logic [XLEN-1:0]          vtype_o,
    input logic [$clog2(VLEN)-1:0]  vstart_o,
    input logic [1:0]               vs_o
);
    int unsigned bound;
    assign bound = ((VLEN / 8) >> vtype_o[4:3]) << vtype_o[1:0];

    assert_ill_zero_vl_R4: assert property (@(posedge clk) disable iff (rst)
        vtype_o[XLEN-1] |-> (vl_o == '0));

    assert_vl_bound_R3: assert property (@(posedge clk) disable iff (rst)
        !vtype_o[XLEN-1] |-> (32'(vl_o) <= bound));

    assert_retire_clears_R6: assert property (@(posedge clk) disable iff (rst)
        retire_i |=> (vstart_o == '0));

    assert_arith_midrun_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid_i && issue_kind_i == 2'b00 && vstart_o != '0) |-> issue_illegal_o);

    assert_vlenb_const_R2: assert property (@(posedge clk) disable iff (rst)
        (csr_valid_i && csr_addr_i == 12'hC22) |-> (csr_rdata_o == XLEN'(VLEN / 8)));

    assert_vxsat_narrow_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_valid_i && !csr_we_i && csr_addr_i == 12'h009) |-> (csr_rdata_o[XLEN-1:1] == '0));

    assert_dirty_mark_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid_i || retire_i) |=> (vs_o == 2'b11));

    assert_vs_nonoff_R1: assert property (@(posedge clk) disable iff (rst)
        vs_o != 2'b00);

endmodule

bind vcfg_unit vcfg_checker #(.XLEN(XLEN), .VLEN(VLEN)) u_vcfg_checker (
    .clk             (clk),
    .rst             (rst),
    .csr_valid_i     (csr_valid_i),
    .csr_we_i        (csr_we_i),
    .csr_addr_i      (csr_addr_i),
    .csr_rdata_o     (csr_rdata_o),
    .cfg_valid_i     (cfg_valid_i),
    .issue_valid_i   (issue_valid_i),
    .issue_kind_i    (issue_kind_i),
    .issue_illegal_o (issue_illegal_o),
    .retire_i        (retire_i),
    .vl_o            (vl_o),
    .vtype_o         (vtype_o),
    .vstart_o        (vstart_o),
    .vs_o            (vs_o)
);

// File: tb/vcfg_unit_bench.sv
`timescale 1ns/1ps
module vcfg_unit_bench;
    localparam int XLEN = 64;
    localparam int VLEN = 128;
    localparam logic [63:0] ILL = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [63:0] vt;
        logic [63:0] avl;
        logic [7:0]  vl;
        logic        ill;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{64'h00,  64'd100,  8'd16,  1'b0},
        '{64'h03,  64'd100,  8'd100, 1'b0},
        '{64'h18,  64'd5,    8'd2,   1'b0},
        '{64'h12,  64'd16,   8'd16,  1'b0},
        '{64'h09,  64'd3,    8'd3,   1'b0},
        '{64'h20,  64'd50,   8'd0,   1'b1},
        '{64'h05,  64'd50,   8'd0,   1'b1},
        '{64'h00,  64'd0,    8'd0,   1'b0},
        '{64'hDB,  64'd1000, 8'd16,  1'b0},
        '{64'h100, 64'd10,   8'd0,   1'b1},
        '{64'h0A,  64'd33,   8'd32,  1'b0},
        '{64'h04,  64'd7,    8'd0,   1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            csr_valid_i = 1'b0, csr_we_i = 1'b0;
    logic [11:0]     csr_addr_i = '0;
    logic [63:0]     csr_wdata_i = '0;
    logic [63:0]     csr_rdata_o;
    logic            csr_hit_o;
    logic            cfg_valid_i = 1'b0;
    logic [63:0]     cfg_avl_i = '0, cfg_vtype_i = '0;
    logic [7:0]      cfg_vl_o;
    logic            sat_set_i = 1'b0;
    logic            issue_valid_i = 1'b0;
    logic [1:0]      issue_kind_i = '0;
    logic            issue_illegal_o;
    logic            retire_i = 1'b0;
    logic [7:0]      vl_o;
    logic [63:0]     vtype_o;
    logic [6:0]      vstart_o;
    logic [1:0]      vxrm_o;
    logic [1:0]      vs_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN)) u_vcfg_unit (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_valid_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        @(negedge clk);
        csr_valid_i = 1'b0; csr_we_i = 1'b0;
    endtask

    task automatic csr_rd(input logic [11:0] a, output logic [63:0] d, output logic hit);
        @(negedge clk);
        csr_valid_i = 1'b1; csr_we_i = 1'b0; csr_addr_i = a;
        #1;
        d = csr_rdata_o; hit = csr_hit_o;
        csr_valid_i = 1'b0;
    endtask

    task automatic configure(input logic [63:0] vt, input logic [63:0] avl, output logic [7:0] granted);
        @(negedge clk);
        cfg_valid_i = 1'b1; cfg_vtype_i = vt; cfg_avl_i = avl;
        #1 granted = cfg_vl_o;
        @(negedge clk);
        cfg_valid_i = 1'b0;
    endtask

    task automatic probe_issue(input logic [1:0] k, output logic ill);
        @(negedge clk);
        issue_valid_i = 1'b1; issue_kind_i = k;
        #1 ill = issue_illegal_o;
        issue_valid_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        logic        h;
        logic [7:0]  g;
        logic        il;

        do_reset();
        // R1 reset state
        chk("R1 vl", 64'(vl_o), 64'd0);
        chk("R1 vtype", vtype_o, ILL);
        chk("R1 vstart", 64'(vstart_o), 64'd0);
        chk("R1 vs", 64'(vs_o), 64'd1);
        chk("R1 vxrm", 64'(vxrm_o), 64'd0);
        csr_rd(12'h009, d, h); chk("R1 vxsat", d, 64'd0);
        // R2 map
        csr_rd(12'hC22, d, h); chk("R2 vlenb", d, 64'd16); chk("R2 hit", 64'(h), 64'd1);
        csr_rd(12'h123, d, h); chk("R2 miss data", d, 64'd0); chk("R2 miss hit", 64'(h), 64'd0);
        // R10 reads and issue checks leave state alone
        probe_issue(2'b00, il);
        @(negedge clk) chk("R10 untouched", 64'(vs_o), 64'd1);

        // R3 and R4 table walk
        for (int i = 0; i < NV; i++) begin
            configure(TBL[i].vt, TBL[i].avl, g);
            chk("R3 granted", 64'(g), 64'(TBL[i].vl));
            chk("R3 vl reg", 64'(vl_o), 64'(TBL[i].vl));
            chk("R4 vtype", vtype_o, TBL[i].ill ? ILL : TBL[i].vt);
            csr_rd(12'hC20, d, h); chk("R2 vl read", d, 64'(TBL[i].vl));
        end
        chk("R10 after cfg", 64'(vs_o), 64'd3);

        // R5 read-only
        configure(64'h09, 64'd5, g);
        csr_wr(12'hC20, 64'h55);  chk("R5 vl", 64'(vl_o), 64'd5);
        csr_wr(12'hC21, 64'h00);  chk("R5 vtype", vtype_o, 64'h09);
        csr_wr(12'hC22, 64'h99);  csr_rd(12'hC22, d, h); chk("R5 vlenb", d, 64'd16);

        // R6 vstart
        do_reset();
        csr_wr(12'h008, 64'h1FF);
        chk("R6 trunc", 64'(vstart_o), 64'h7F);
        chk("R10 vstart write", 64'(vs_o), 64'd3);
        @(negedge clk) retire_i = 1'b1;
        @(negedge clk) retire_i = 1'b0;
        chk("R6 retire", 64'(vstart_o), 64'd0);
        @(negedge clk);
        csr_valid_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = 12'h008; csr_wdata_i = 64'd9;
        retire_i = 1'b1;
        @(negedge clk);
        csr_valid_i = 1'b0; csr_we_i = 1'b0; retire_i = 1'b0;
        chk("R6 retire wins", 64'(vstart_o), 64'd0);

        // R10 retire alone marks dirty
        do_reset();
        @(negedge clk) retire_i = 1'b1;
        @(negedge clk) retire_i = 1'b0;
        chk("R10 retire", 64'(vs_o), 64'd3);

        // R7 issue legality
        configure(64'h00, 64'd16, g);
        csr_wr(12'h008, 64'd5);
        probe_issue(2'b00, il); chk("R7 arith midrun", 64'(il), 64'd1);
        probe_issue(2'b01, il); chk("R7 load midrun", 64'(il), 64'd1);
        probe_issue(2'b10, il); chk("R7 store midrun", 64'(il), 64'd0);
        csr_wr(12'h008, 64'd0);
        probe_issue(2'b00, il); chk("R7 arith start", 64'(il), 64'd0);
        configure(64'h20, 64'd16, g);
        probe_issue(2'b10, il); chk("R7 store vill", 64'(il), 64'd1);

        // R8 vxsat
        csr_wr(12'h009, 64'hFF); csr_rd(12'h009, d, h); chk("R8 one bit", d, 64'd1);
        csr_wr(12'h009, 64'h0);  csr_rd(12'h009, d, h); chk("R8 clear", d, 64'd0);
        @(negedge clk) sat_set_i = 1'b1;
        @(negedge clk) sat_set_i = 1'b0;
        csr_rd(12'h009, d, h); chk("R8 sticky", d, 64'd1);
        @(negedge clk);
        csr_valid_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = 12'h009; csr_wdata_i = 64'd0;
        sat_set_i = 1'b1;
        @(negedge clk);
        csr_valid_i = 1'b0; csr_we_i = 1'b0; sat_set_i = 1'b0;
        csr_rd(12'h009, d, h); chk("R8 write or set", d, 64'd1);

        // R9 vxrm and vcsr
        csr_wr(12'h00A, 64'h7);
        csr_rd(12'h00A, d, h); chk("R9 vxrm", d, 64'd3);
        chk("R9 vxrm port", 64'(vxrm_o), 64'd3);
        csr_rd(12'h00F, d, h); chk("R9 vcsr view", d, 64'h7);
        csr_wr(12'h00F, 64'h4);
        csr_rd(12'h009, d, h); chk("R9 vcsr sat", d, 64'd0);
        chk("R9 vcsr rm", 64'(vxrm_o), 64'd2);
        csr_wr(12'h00F, 64'hFA);
        csr_rd(12'h00F, d, h); chk("R9 vcsr upper", d, 64'h2);

        finish_run();
    end

endmodule